// File: doc/BRIEF.md
# Serial Port Buffer and Error-Flag Controller

This block sits between a CPU register interface and the shift engine of a synchronous serial port. It holds two small word queues: one carries words the CPU writes toward the shifter for sending, and the other carries words the shifter has received toward the CPU. For each queue it reports a full flag, an empty flag and a fill count. The shift engine, its clocking and any chip-select timing stay outside the block.

Two error conditions are kept as sticky flags. A CPU write into a full send queue is discarded and sets a write-overflow flag without raising any interrupt. Software clears that flag by reading the status register. A word arriving while the receive queue is full is also dropped; it sets an overrun flag and pulses an overrun interrupt. Software clears the overrun flag by writing a clear strobe, and that strobe is obeyed only once the receive queue is no longer full. A flush control empties both queues while the port is disabled and leaves every error flag as it was.

Top module: `sio_fifo_ctrl`

## Requirements
- R1: Each queue holds DEPTH (default 4) words. The fill count (3 bits) equals accepted writes minus accepted reads. Full is 1 exactly when the count is 4, and empty is 1 exactly when the count is 0.
- R2: After reset both queues are empty and not full, both counts are 0, wr_ovf, ovr_flag and ovr_irq are 0, and cpu_rdata is 0.
- R3: Words leave each queue in the order they entered. tx_data always shows the oldest queued send word. A push and a pop in the same cycle on a queue that is neither full nor empty leave its count unchanged.
- R4: A cpu_wr while the send queue is full stores nothing and leaves the count at 4. It sets wr_ovf in the next cycle, and ovr_irq stays 0.
- R5: A stat_rd strobe clears wr_ovf in the next cycle. If a new overflow happens in the same cycle, wr_ovf stays 1.
- R6: An rx_push while the receive queue is full drops the word. In the next cycle ovr_flag is 1 and ovr_irq is 1 for exactly one cycle.
- R7: ovr_clr clears ovr_flag in the next cycle only when the receive queue is not full. While the queue is full, ovr_clr is ignored.
- R8: flush with port_en = 0 returns both queues to empty (count 0, full 0) in the next cycle. flush with port_en = 1 has no effect.
- R9: A flush leaves wr_ovf and ovr_flag unchanged.
- R10: cpu_rd on an empty receive queue leaves cpu_rdata at its last value and the count at 0.
- R11: tx_pop on an empty send queue leaves the count at 0 and the queue empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| port_en | input | 1 | Port enable; while 1, flush is not obeyed |
| flush | input | 1 | Queue flush control level |
| stat_rd | input | 1 | Status register read strobe; clears wr_ovf |
| ovr_clr | input | 1 | Overrun clear strobe |
| cpu_wr | input | 1 | CPU write into the send queue |
| cpu_wdata | input | DATA_W | CPU write word |
| cpu_rd | input | 1 | CPU read from the receive queue |
| cpu_rdata | output | DATA_W | Registered word from the last accepted read |
| tx_pop | input | 1 | Shifter takes the oldest send word |
| tx_data | output | DATA_W | Oldest send word |
| rx_push | input | 1 | Shifter delivers a received word |
| rx_data | input | DATA_W | Received word |
| tx_full | output | 1 | Send queue full |
| tx_empty | output | 1 | Send queue empty |
| tx_depth | output | CNT_W | Send queue fill count |
| rx_full | output | 1 | Receive queue full |
| rx_empty | output | 1 | Receive queue empty |
| rx_depth | output | CNT_W | Receive queue fill count |
| wr_ovf | output | 1 | Sticky write-overflow flag |
| ovr_flag | output | 1 | Sticky overrun flag |
| ovr_irq | output | 1 | One-cycle overrun interrupt pulse |

## Verification
Every registered result appears one clock after the edge that samples its stimulus. This covers the counts, the full and empty flags, cpu_rdata, both error flags and the overrun pulse. tx_data follows the send queue's read pointer with no added delay, so it also changes at that edge. The bench applies each stimulus just after a rising edge, holds it across the next edge, and compares the outputs 1 ns after that edge. The ovr_irq pulse is checked once at the edge after the overrun and again one cycle later, where it must be 0.

// File: rtl/sio_fifo_pkg.sv
`timescale 1ns/1ps
package sio_fifo_pkg;

  // Next pointer value for a circular buffer of 'depth' slots.
  function automatic int ring_step(input int ptr, input int depth);
    return (ptr == depth - 1) ? 0 : ptr + 1;
  endfunction

  // Fill count after one cycle of accepted push/pop.
  function automatic int level_next(input int lvl, input logic push, input logic pop);
    return lvl + (push ? 1 : 0) - (pop ? 1 : 0);
  endfunction

endpackage

// File: rtl/sio_fifo_ring.sv
`timescale 1ns/1ps
module sio_fifo_ring #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 4,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              push,
  input  logic              pop,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] head,
  output logic              full,
  output logic              empty,
  output logic [CNT_W-1:0]  level
);
  import sio_fifo_pkg::*;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr;
  logic [PTR_W-1:0]  rd_ptr;

  // push and pop arrive already qualified against full/empty/clear
  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else if (clear) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (push) wr_ptr <= PTR_W'(ring_step(int'(wr_ptr), DEPTH));
      if (pop)  rd_ptr <= PTR_W'(ring_step(int'(rd_ptr), DEPTH));
      level <= CNT_W'(level_next(int'(level), push, pop));
    end
  end

  assign head  = mem[rd_ptr];
  assign full  = (level == CNT_W'(DEPTH));
  assign empty = (level == '0);

endmodule

// File: rtl/sio_err_flags.sv
`timescale 1ns/1ps
module sio_err_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic ovf_evt,
  input  logic stat_rd,
  input  logic ovr_evt,
  input  logic ovr_clr,
  input  logic rx_full,
  output logic wr_ovf,
  output logic ovr_flag,
  output logic ovr_irq
);
  logic ovr_clr_ok;
  assign ovr_clr_ok = ovr_clr & ~rx_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ovf   <= 1'b0;
      ovr_flag <= 1'b0;
      ovr_irq  <= 1'b0;
    end else begin
      // a new event outranks a clear in the same cycle
      if (ovf_evt)      wr_ovf <= 1'b1;
      else if (stat_rd) wr_ovf <= 1'b0;
      if (ovr_evt)         ovr_flag <= 1'b1;
      else if (ovr_clr_ok) ovr_flag <= 1'b0;
      ovr_irq <= ovr_evt;
    end
  end

endmodule

// File: rtl/sio_fifo_ctrl.sv
`timescale 1ns/1ps
module sio_fifo_ctrl #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 4,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              port_en,
  input  logic              flush,
  input  logic              stat_rd,
  input  logic              ovr_clr,
  input  logic              cpu_wr,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic              cpu_rd,
  output logic [DATA_W-1:0] cpu_rdata,
  input  logic              tx_pop,
  output logic [DATA_W-1:0] tx_data,
  input  logic              rx_push,
  input  logic [DATA_W-1:0] rx_data,
  output logic              tx_full,
  output logic              tx_empty,
  output logic [CNT_W-1:0]  tx_depth,
  output logic              rx_full,
  output logic              rx_empty,
  output logic [CNT_W-1:0]  rx_depth,
  output logic              wr_ovf,
  output logic              ovr_flag,
  output logic              ovr_irq
);
  // named internal events
  logic              flush_act;
  logic              tx_push_ok, tx_pop_ok, rx_push_ok, rx_pop_ok;
  logic              ovf_evt, ovr_evt;
  logic [DATA_W-1:0] rx_head;

  assign flush_act  = flush & ~port_en;
  assign tx_push_ok = cpu_wr  & ~tx_full  & ~flush_act;
  assign tx_pop_ok  = tx_pop  & ~tx_empty & ~flush_act;
  assign rx_push_ok = rx_push & ~rx_full  & ~flush_act;
  assign rx_pop_ok  = cpu_rd  & ~rx_empty & ~flush_act;
  assign ovf_evt    = cpu_wr  &  tx_full  & ~flush_act;
  assign ovr_evt    = rx_push &  rx_full  & ~flush_act;

  sio_fifo_ring #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .clear(flush_act),
    .push(tx_push_ok), .pop(tx_pop_ok), .wdata(cpu_wdata),
    .head(tx_data), .full(tx_full), .empty(tx_empty), .level(tx_depth)
  );

  sio_fifo_ring #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .clear(flush_act),
    .push(rx_push_ok), .pop(rx_pop_ok), .wdata(rx_data),
    .head(rx_head), .full(rx_full), .empty(rx_empty), .level(rx_depth)
  );

  sio_err_flags u_flags (
    .clk(clk), .rst_n(rst_n),
    .ovf_evt(ovf_evt), .stat_rd(stat_rd),
    .ovr_evt(ovr_evt), .ovr_clr(ovr_clr), .rx_full(rx_full),
    .wr_ovf(wr_ovf), .ovr_flag(ovr_flag), .ovr_irq(ovr_irq)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cpu_rdata <= '0;
    else if (rx_pop_ok) cpu_rdata <= rx_head;
  end

endmodule

// File: rtl/sio_fifo_ctrl_chk.sv
`timescale 1ns/1ps
module sio_fifo_ctrl_chk #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 4,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              port_en,
  input logic              flush,
  input logic              stat_rd,
  input logic              cpu_wr,
  input logic              cpu_rd,
  input logic              tx_pop,
  input logic              rx_push,
  input logic [DATA_W-1:0] cpu_rdata,
  input logic              tx_full,
  input logic              tx_empty,
  input logic [CNT_W-1:0]  tx_depth,
  input logic              rx_full,
  input logic              rx_empty,
  input logic [CNT_W-1:0]  rx_depth,
  input logic              wr_ovf,
  input logic              ovr_flag,
  input logic              ovr_irq
);
  logic fl;
  assign fl = flush & ~port_en;

  AST_DEPTH_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    tx_depth <= CNT_W'(DEPTH) && rx_depth <= CNT_W'(DEPTH)); // R1
  AST_NOT_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_full && tx_empty) && !(rx_full && rx_empty)); // R1
  AST_OVF_DISCARD: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_wr && tx_full && !tx_pop && !fl |=> wr_ovf && tx_depth == CNT_W'(DEPTH) && !ovr_irq); // R4
  AST_STAT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd && !(cpu_wr && tx_full && !fl) |=> !wr_ovf); // R5
  AST_OVERRUN_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push && rx_full && !fl |=> ovr_irq && ovr_flag); // R6
  AST_OVR_HOLD_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_flag && rx_full |=> ovr_flag); // R7
  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    fl |=> tx_empty && rx_empty && tx_depth == '0 && rx_depth == '0); // R8
  AST_FLUSH_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    fl && wr_ovf && !stat_rd |=> wr_ovf); // R9
  AST_EMPTY_READ: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rd && rx_empty |=> $stable(cpu_rdata)); // R10

endmodule

bind sio_fifo_ctrl sio_fifo_ctrl_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .port_en(port_en), .flush(flush), .stat_rd(stat_rd),
  .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .tx_pop(tx_pop), .rx_push(rx_push),
  .cpu_rdata(cpu_rdata), .tx_full(tx_full), .tx_empty(tx_empty), .tx_depth(tx_depth),
  .rx_full(rx_full), .rx_empty(rx_empty), .rx_depth(rx_depth),
  .wr_ovf(wr_ovf), .ovr_flag(ovr_flag), .ovr_irq(ovr_irq)
);

// File: tb/sio_fifo_ctrl_test.sv
`timescale 1ns/1ps
module sio_fifo_ctrl_test;
  localparam int DW = 8;
  localparam int DP = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic port_en = 0, flush = 0, stat_rd = 0, ovr_clr = 0;
  logic cpu_wr = 0, cpu_rd = 0, tx_pop = 0, rx_push = 0;
  logic [DW-1:0] cpu_wdata = '0, rx_data = '0;
  logic [DW-1:0] cpu_rdata, tx_data;
  logic tx_full, tx_empty, rx_full, rx_empty, wr_ovf, ovr_flag, ovr_irq;
  logic [2:0] tx_depth, rx_depth;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  sio_fifo_ctrl #(.DATA_W(DW), .DEPTH(DP)) uut (
    .clk(clk), .rst_n(rst_n), .port_en(port_en), .flush(flush), .stat_rd(stat_rd),
    .ovr_clr(ovr_clr), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata), .cpu_rd(cpu_rd),
    .cpu_rdata(cpu_rdata), .tx_pop(tx_pop), .tx_data(tx_data), .rx_push(rx_push),
    .rx_data(rx_data), .tx_full(tx_full), .tx_empty(tx_empty), .tx_depth(tx_depth),
    .rx_full(rx_full), .rx_empty(rx_empty), .rx_depth(rx_depth),
    .wr_ovf(wr_ovf), .ovr_flag(ovr_flag), .ovr_irq(ovr_irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // one clock: inputs held across the edge, outputs read 1 ns after it
  task automatic cyc();
    @(posedge clk);
    #1;
    cpu_wr = 0; cpu_rd = 0; tx_pop = 0; rx_push = 0; stat_rd = 0; ovr_clr = 0;
  endtask

  task automatic wr_tx(input logic [DW-1:0] d);
    cpu_wr = 1; cpu_wdata = d; cyc();
  endtask
  task automatic push_rx(input logic [DW-1:0] d);
    rx_push = 1; rx_data = d; cyc();
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    #100000;
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    finish_run();
  end

  initial begin
    repeat (2) @(posedge clk);
    #1 rst_n = 1;
    // R2 reset state
    chk("R2 tx_empty", tx_empty, 1); chk("R2 tx_full", tx_full, 0);
    chk("R2 rx_empty", rx_empty, 1); chk("R2 depths", tx_depth + rx_depth, 0);
    chk("R2 flags", {wr_ovf, ovr_flag, ovr_irq}, 0); chk("R2 rdata", cpu_rdata, 0);

    // R1/R4 send queue fill sweep past capacity
    for (int i = 0; i < 6; i++) begin
      wr_tx(DW'(8'h10 + i));
      chk("R1 tx_depth", tx_depth, (i + 1 > DP) ? DP : i + 1);
      chk("R1 tx_full", tx_full, (i >= DP - 1) ? 1 : 0);
      chk("R1 tx_empty", tx_empty, 0);
      chk("R4 wr_ovf", wr_ovf, (i >= DP) ? 1 : 0);
      chk("R4 no irq", ovr_irq, 0);
    end
    chk("R3 tx head", tx_data, 8'h10);

    // R5 clear by status read, set wins over clear
    stat_rd = 1; cyc(); chk("R5 cleared", wr_ovf, 0);
    wr_tx(8'hEE); chk("R4 set again", wr_ovf, 1);
    stat_rd = 1; cpu_wr = 1; cpu_wdata = 8'hEF; cyc(); chk("R5 set wins", wr_ovf, 1);
    stat_rd = 1; cyc(); chk("R5 cleared again", wr_ovf, 0);

    // R3 drain in order; discarded words never appear (R4)
    for (int i = 0; i < DP; i++) begin
      chk("R3 tx order", tx_data, 8'h10 + i);
      tx_pop = 1; cyc();
      chk("R1 tx_depth drain", tx_depth, DP - 1 - i);
    end
    chk("R1 tx_empty", tx_empty, 1);
    tx_pop = 1; cyc();
    chk("R11 pop empty depth", tx_depth, 0); chk("R11 pop empty flag", tx_empty, 1);

    // R3 simultaneous push and pop
    wr_tx(8'hA0); wr_tx(8'hA1);
    cpu_wr = 1; cpu_wdata = 8'hA2; tx_pop = 1; cyc();
    chk("R3 same-cycle depth", tx_depth, 2); chk("R3 same-cycle head", tx_data, 8'hA1);
    tx_pop = 1; cyc(); chk("R3 after A1", tx_data, 8'hA2);
    tx_pop = 1; cyc(); chk("R3 drained", tx_depth, 0);

    // R1/R6 receive queue fill with overrun
    for (int i = 0; i < 5; i++) begin
      push_rx(DW'(8'h30 + i));
      chk("R1 rx_depth", rx_depth, (i + 1 > DP) ? DP : i + 1);
      chk("R1 rx_full", rx_full, (i >= DP - 1) ? 1 : 0);
      chk("R6 ovr_flag", ovr_flag, (i >= DP) ? 1 : 0);
      chk("R6 ovr_irq", ovr_irq, (i == DP) ? 1 : 0);
    end
    cyc(); chk("R6 irq one cycle", ovr_irq, 0); chk("R6 flag sticky", ovr_flag, 1);

    // R7 clear refused while full, accepted after a read
    ovr_clr = 1; cyc(); chk("R7 ignored when full", ovr_flag, 1);
    cpu_rd = 1; cyc(); chk("R3 rx first", cpu_rdata, 8'h30); chk("R1 rx_depth 3", rx_depth, 3);
    ovr_clr = 1; cyc(); chk("R7 cleared", ovr_flag, 0);
    for (int i = 1; i < DP; i++) begin
      cpu_rd = 1; cyc(); chk("R3 rx order", cpu_rdata, 8'h30 + i);
    end
    // R10 read from empty
    cpu_rd = 1; cyc();
    chk("R10 rdata held", cpu_rdata, 8'h33); chk("R10 depth", rx_depth, 0);

    // R8/R9 flush
    for (int i = 0; i <= DP; i++) wr_tx(DW'(i));
    for (int i = 0; i <= DP; i++) push_rx(DW'(i));
    cyc();
    port_en = 1; flush = 1; cyc();
    chk("R8 enabled tx kept", tx_depth, DP); chk("R8 enabled rx kept", rx_depth, DP);
    port_en = 0; cyc();
    chk("R8 tx flushed", {tx_full, tx_empty, tx_depth}, 5'b01000);
    chk("R8 rx flushed", {rx_full, rx_empty, rx_depth}, 5'b01000);
    chk("R9 wr_ovf kept", wr_ovf, 1); chk("R9 ovr_flag kept", ovr_flag, 1);
    flush = 0; cyc();
    wr_tx(8'h5A); chk("R8 usable after flush", tx_data, 8'h5A);

    finish_run();
  end
endmodule